// File: doc/BRIEF.md
# CAN Bus Wake-up Pattern Filter

This block decides when traffic on a CAN bus should wake the system. It watches two sources. The first source is the sampled bus level, which goes to a sequence detector for the conventional wake-up. The second source is the stream of completed frames from an external frame receiver. These feed a payload matcher for the selective, or global, wake-up that partial networking uses. Frame bit decoding, CRC checking and identifier filtering are done elsewhere. The identifier of a frame is never looked at.

One enable input picks the path. With partial networking off, only the bus-level sequence can wake. With it on, only a pair of fixed 8-byte payloads can wake, and they must arrive in order within a timeout. A listen-mode entry pulse restarts the filter. If the entry came straight from the offline state, a window opens in which the second payload alone is enough to wake. Every wake-up produces a one-cycle event pulse, together with a flag that names the path that fired.

Top module: `canwake_filter`

## Requirements
- R1: With `pnEnable` low, the bus sequence dominant, recessive, dominant, recessive (`busLevel` 0 = dominant, 1 = recessive) wakes the system when each phase lasts at least MIN_PHASE samples. `wakeEvent` and `wakeConv` go high right after the clock edge that samples the MIN_PHASE-th recessive level of the last phase.
- R2: If a phase that the sequence is expecting ends before MIN_PHASE samples, detection restarts, and the run that follows can begin a new sequence. A final recessive phase shorter than MIN_PHASE gives no wake-up.
- R3: Partial networking changes which path can wake:
  - With `pnEnable` high, the bus sequence never wakes.
  - With `pnEnable` low, frames never wake.
- R4: Frame matching rules:
  - A frame counts only when `frameValid` is sampled high and `frameLen` is 8.
  - Byte i of the payload is `frameData[8*i+7:8*i]`.
  - The initial payload is C6 EE EE EE EE EE EE EF, byte 0 first.
  - The wake payload is C6 EE EE EE EE EE EE 37, byte 0 first.
- R5: With `pnEnable` high, a wake payload that follows an initial payload wakes the system when it is sampled no more than TIMEOUT clock edges after the initial one. `wakeEvent` and `wakeGlobal` go high right after the edge that samples the wake payload.
- R6: A wake payload sampled later than TIMEOUT edges after the initial payload is discarded and gives no wake-up.
- R7: Certain frames neither advance the sequence nor reset it:
  - a frame whose length is not 8;
  - a frame with any byte that does not match;
  - a mismatching frame that arrives between the two payloads.
- R8: After a `listenEntry` pulse with `fromOffline` high, a wake payload alone wakes the system when it is sampled no more than TIMEOUT edges after the entry.
- R9: Once that entry window has expired, a wake payload alone is ignored, and both payloads in order are needed again.
- R10: A wake payload with no initial payload before it, and with no direct-from-offline window open, is ignored.
- R11: After reset all outputs are low.
- R12: `wakeEvent` lasts one cycle. Exactly one of `wakeConv` and `wakeGlobal` is high with it, and neither is high without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busLevel | input | 1 | Synchronised bus level, 0 dominant, 1 recessive |
| pnEnable | input | 1 | Partial-networking enable |
| fromOffline | input | 1 | Listen state was entered straight from offline |
| listenEntry | input | 1 | One-cycle pulse on entry to the listen state |
| frameValid | input | 1 | One-cycle strobe for a completed frame |
| frameLen | input | 4 | Data length of the frame |
| frameData | input | 64 | Payload, byte i at bits 8*i+7:8*i |
| wakeEvent | output | 1 | One-cycle wake-up pulse |
| wakeConv | output | 1 | The wake-up came from the bus sequence |
| wakeGlobal | output | 1 | The wake-up came from the payload pair |

## Verification
The bench targets the exact timeout boundaries. It samples a payload TIMEOUT edges after the initial payload, and again one edge later. It does the same after a direct-from-offline entry. An off-by-one timer would miss the first of these wake-ups or accept the second. It inserts phases one sample short, both in the middle of the bus sequence and at its end. A detector that fails to restart would wake early, and one that restarts too eagerly would miss the wake-up after the glitch. It also sends wrong-length frames, corrupted frames and a wake payload with no initial payload before it. A design that resets on noise, ignores the length, or skips the ordering rule shows up as a missed or extra event.

// File: rtl/canwake_pkg.sv
package canwake_pkg;
  // byte 0 sits in the low bits
  localparam logic [63:0] INIT_PAYLOAD = 64'hEF_EE_EE_EE_EE_EE_EE_C6;
  localparam logic [63:0] WAKE_PAYLOAD = 64'h37_EE_EE_EE_EE_EE_EE_C6;
  localparam logic [3:0]  FULL_LEN     = 4'd8;
  localparam int          NUM_BYTES    = 8;

  typedef struct packed {
    logic tmrLoad;
    logic tmrRun;
  } ctlStrobe_t;

  typedef struct packed {
    logic busEdge;
    logic prevLevel;
    logic longRun;
    logic recHeld;
    logic initHit;
    logic wakeHit;
    logic tmrExpire;
  } dpStatus_t;
endpackage

// File: rtl/canwake_datapath.sv
module canwake_datapath
  import canwake_pkg::*;
#(
  parameter int MIN_PHASE = 6,
  parameter int TIMEOUT   = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busLevel,
  input  logic        frameValid,
  input  logic [3:0]  frameLen,
  input  logic [63:0] frameData,
  input  ctlStrobe_t  ctl,
  output dpStatus_t   st
);
  localparam int RUN_W = $clog2(MIN_PHASE + 1);
  localparam int TMR_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_PHASE);
  localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(MIN_PHASE - 1);
  localparam logic [TMR_W-1:0] TMR_END = TMR_W'(TIMEOUT - 1);

  logic             lastLevel;
  logic [RUN_W-1:0] runLen;
  logic [TMR_W-1:0] tmrCnt;
  logic [NUM_BYTES-1:0] initByteOk, wakeByteOk;
  logic             busEdge, frameOk;

  assign busEdge = busLevel != lastLevel;

  // run-length of the current bus level, saturating at MIN_PHASE
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastLevel <= 1'b1;
      runLen    <= '0;
    end else begin
      lastLevel <= busLevel;
      if (busEdge)              runLen <= RUN_W'(1);
      else if (runLen != RUN_MAX) runLen <= runLen + RUN_W'(1);
    end
  end

  // per-byte payload comparators
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_cmp
    assign initByteOk[i] = frameData[8*i +: 8] == INIT_PAYLOAD[8*i +: 8];
    assign wakeByteOk[i] = frameData[8*i +: 8] == WAKE_PAYLOAD[8*i +: 8];
  end

  assign frameOk = frameValid && (frameLen == FULL_LEN);

  // window timer shared by both timeout uses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 tmrCnt <= '0;
    else if (ctl.tmrLoad)                      tmrCnt <= '0;
    else if (ctl.tmrRun && tmrCnt != TMR_END)  tmrCnt <= tmrCnt + TMR_W'(1);
  end

  always_comb begin
    st.busEdge   = busEdge;
    st.prevLevel = lastLevel;
    st.longRun   = runLen >= RUN_MAX;
    st.recHeld   = !busEdge && lastLevel && (runLen >= RUN_PRE);
    st.initHit   = frameOk && (&initByteOk);
    st.wakeHit   = frameOk && (&wakeByteOk);
    st.tmrExpire = tmrCnt == TMR_END;
  end
endmodule

// File: rtl/canwake_ctrl.sv
module canwake_ctrl
  import canwake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pnEnable,
  input  logic       fromOffline,
  input  logic       listenEntry,
  input  dpStatus_t  st,
  output ctlStrobe_t ctl,
  output logic       wakeEvent,
  output logic       wakeConv,
  output logic       wakeGlobal
);
  logic [1:0] convStage;   // expected level of the current phase is convStage[0]
  logic       gotInit, directWin, armed;

  assign armed = gotInit || directWin;

  always_comb begin
    ctl.tmrLoad = pnEnable && (listenEntry ? fromOffline : st.initHit);
    ctl.tmrRun  = armed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convStage  <= '0;
      gotInit    <= 1'b0;
      directWin  <= 1'b0;
      wakeEvent  <= 1'b0;
      wakeConv   <= 1'b0;
      wakeGlobal <= 1'b0;
    end else begin
      wakeEvent  <= 1'b0;
      wakeConv   <= 1'b0;
      wakeGlobal <= 1'b0;

      // bus-level sequence
      if (pnEnable || listenEntry) begin
        convStage <= '0;
      end else if (st.busEdge) begin
        if (st.prevLevel == convStage[0] && st.longRun && convStage != 2'd3)
          convStage <= convStage + 2'd1;
        else
          convStage <= '0;
      end else if (convStage == 2'd3 && st.recHeld) begin
        convStage <= '0;
        wakeEvent <= 1'b1;
        wakeConv  <= 1'b1;
      end

      // payload pair
      if (!pnEnable) begin
        gotInit   <= 1'b0;
        directWin <= 1'b0;
      end else if (listenEntry) begin
        gotInit   <= 1'b0;
        directWin <= fromOffline;
      end else if (st.wakeHit && armed) begin
        gotInit    <= 1'b0;
        directWin  <= 1'b0;
        wakeEvent  <= 1'b1;
        wakeGlobal <= 1'b1;
      end else if (st.initHit) begin
        gotInit   <= 1'b1;
        directWin <= 1'b0;
      end else if (armed && st.tmrExpire) begin
        gotInit   <= 1'b0;
        directWin <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/canwake_filter.sv
module canwake_filter
  import canwake_pkg::*;
#(
  parameter int MIN_PHASE = 6,
  parameter int TIMEOUT   = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busLevel,
  input  logic        pnEnable,
  input  logic        fromOffline,
  input  logic        listenEntry,
  input  logic        frameValid,
  input  logic [3:0]  frameLen,
  input  logic [63:0] frameData,
  output logic        wakeEvent,
  output logic        wakeConv,
  output logic        wakeGlobal
);
  ctlStrobe_t ctl;
  dpStatus_t  st;

  canwake_datapath #(.MIN_PHASE(MIN_PHASE), .TIMEOUT(TIMEOUT)) u_dp (
    .clk(clk), .rstN(rstN), .busLevel(busLevel), .frameValid(frameValid),
    .frameLen(frameLen), .frameData(frameData), .ctl(ctl), .st(st)
  );

  canwake_ctrl u_ctl (
    .clk(clk), .rstN(rstN), .pnEnable(pnEnable), .fromOffline(fromOffline),
    .listenEntry(listenEntry), .st(st), .ctl(ctl),
    .wakeEvent(wakeEvent), .wakeConv(wakeConv), .wakeGlobal(wakeGlobal)
  );
endmodule

// File: rtl/canwake_checker.sv
module canwake_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busLevel,
  input logic       pnEnable,
  input logic       frameValid,
  input logic [3:0] frameLen,
  input logic       wakeEvent,
  input logic       wakeConv,
  input logic       wakeGlobal
);
  assert_one_kind_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wakeConv, wakeGlobal}));
  assert_kind_needs_event_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wakeConv || wakeGlobal) |-> wakeEvent);
  assert_event_has_kind_R12: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvent |-> (wakeConv || wakeGlobal));
  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvent |=> !wakeEvent);
  assert_conv_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    wakeConv |-> !$past(pnEnable));
  assert_global_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    wakeGlobal |-> $past(pnEnable));
  assert_global_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    wakeGlobal |-> ($past(frameValid) && $past(frameLen) == 4'd8));
  assert_conv_recessive_R1: assert property (@(posedge clk) disable iff (!rstN)
    wakeConv |-> $past(busLevel));
endmodule

bind canwake_filter canwake_checker u_chk (
  .clk(clk), .rstN(rstN), .busLevel(busLevel), .pnEnable(pnEnable),
  .frameValid(frameValid), .frameLen(frameLen), .wakeEvent(wakeEvent),
  .wakeConv(wakeConv), .wakeGlobal(wakeGlobal)
);

// File: tb/sim_canwake_filter.sv
module sim_canwake_filter;
  localparam int MINP = 6;
  localparam int TMO  = 40;
  localparam logic [63:0] INIT_P = 64'hEF_EE_EE_EE_EE_EE_EE_C6;
  localparam logic [63:0] WAKE_P = 64'h37_EE_EE_EE_EE_EE_EE_C6;

  logic clk = 1'b0, rstN = 1'b0;
  logic busLevel = 1'b1, pnEnable = 1'b0, fromOffline = 1'b0, listenEntry = 1'b0;
  logic frameValid = 1'b0;
  logic [3:0] frameLen = 4'd0;
  logic [63:0] frameData = '0;
  logic wakeEvent, wakeConv, wakeGlobal;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;
  int    dueQ[$];
  bit    kindQ[$];   // 1 = global
  string reqQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  canwake_filter #(.MIN_PHASE(MINP), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rstN(rstN), .busLevel(busLevel), .pnEnable(pnEnable),
    .fromOffline(fromOffline), .listenEntry(listenEntry), .frameValid(frameValid),
    .frameLen(frameLen), .frameData(frameData), .wakeEvent(wakeEvent),
    .wakeConv(wakeConv), .wakeGlobal(wakeGlobal)
  );

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if ((wakeConv || wakeGlobal) && !wakeEvent) begin
        total++; bad++;
        $display("FAIL R12 kind flag without event: conv=%0b glob=%0b expected event=1", wakeConv, wakeGlobal);
      end
      if (wakeEvent) begin
        total++;
        if (dueQ.size() == 0) begin
          bad++;
          $display("FAIL unexpected wake at cycle %0d: conv=%0b glob=%0b expected none", cyc, wakeConv, wakeGlobal);
        end else begin
          automatic int    d = dueQ.pop_front();
          automatic bit    k = kindQ.pop_front();
          automatic string r = reqQ.pop_front();
          if (cyc != d || wakeGlobal != k || wakeConv != !k) begin
            bad++;
            $display("FAIL %s: cycle=%0d glob=%0b conv=%0b expected cycle=%0d glob=%0b", r, cyc, wakeGlobal, wakeConv, d, k);
          end
        end
      end
    end
  end

  task automatic expectWake(input int due, input bit isGlobal, input string req);
    dueQ.push_back(due); kindQ.push_back(isGlobal); reqQ.push_back(req);
  endtask

  task automatic expectQuiet(input string req);
    repeat (3) @(negedge clk);
    total++;
    if (dueQ.size() != 0) begin
      bad++;
      $display("FAIL %s: %0d expected wake(s) missing, expected 0 pending", req, dueQ.size());
      dueQ.delete(); kindQ.delete(); reqQ.delete();
    end
  endtask

  task automatic holdBus(input logic lvl, input int n);
    busLevel = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [63:0] d, input logic [3:0] len);
    frameData = d; frameLen = len; frameValid = 1'b1;
    @(negedge clk);
    frameValid = 1'b0; frameData = '0; frameLen = 4'd0;
  endtask

  task automatic enterListen(input logic direct);
    fromOffline = direct; listenEntry = 1'b1;
    @(negedge clk);
    listenEntry = 1'b0; fromOffline = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (wakeEvent || wakeConv || wakeGlobal) begin
      bad++;
      $display("FAIL R11 outputs in reset: %b%b%b expected 000", wakeEvent, wakeConv, wakeGlobal);
    end
    rstN = 1'b1;
    idle(2);
    total++;
    if (wakeEvent || wakeConv || wakeGlobal) begin
      bad++;
      $display("FAIL R11 outputs after reset: %b%b%b expected 000", wakeEvent, wakeConv, wakeGlobal);
    end

    // R1: clean sequence with minimum phases
    holdBus(0, MINP); holdBus(1, MINP); holdBus(0, MINP);
    expectWake(cyc + MINP, 1'b0, "R1");
    holdBus(1, MINP + 4);
    expectQuiet("R1");

    // R1: longer phases
    holdBus(0, MINP + 5); holdBus(1, MINP + 2); holdBus(0, MINP + 9);
    expectWake(cyc + MINP, 1'b0, "R1 long");
    holdBus(1, MINP + 4);
    expectQuiet("R1 long");

    // R2: short middle dominant restarts; following four phases wake
    holdBus(0, MINP); holdBus(1, MINP); holdBus(0, MINP - 1); holdBus(1, MINP);
    expectQuiet("R2 glitch");
    holdBus(0, MINP); holdBus(1, MINP); holdBus(0, MINP);
    expectWake(cyc + MINP, 1'b0, "R2 after restart");
    holdBus(1, MINP + 3);
    expectQuiet("R2 after restart");

    // R2: final recessive too short
    holdBus(0, MINP); holdBus(1, MINP); holdBus(0, MINP); holdBus(1, MINP - 1);
    holdBus(0, 2); holdBus(1, MINP - 2);
    expectQuiet("R2 short final");
    holdBus(1, MINP + 4);

    // R3: frames ignored with pnEnable low
    enterListen(1'b1);
    sendFrame(INIT_P, 4'd8); sendFrame(WAKE_P, 4'd8);
    expectQuiet("R3 frames when pn off");

    // R3: bus sequence ignored with pnEnable high
    pnEnable = 1'b1;
    idle(2);
    holdBus(0, MINP); holdBus(1, MINP); holdBus(0, MINP); holdBus(1, MINP + 4);
    expectQuiet("R3 bus when pn on");

    // R10: wake alone without direct entry
    enterListen(1'b0);
    sendFrame(WAKE_P, 4'd8);
    expectQuiet("R10");

    // R5 / R4: init then wake
    sendFrame(INIT_P, 4'd8);
    idle(3);
    expectWake(cyc + 1, 1'b1, "R5");
    sendFrame(WAKE_P, 4'd8);
    expectQuiet("R5");
    sendFrame(WAKE_P, 4'd8);
    expectQuiet("R10 state cleared after wake");

    // R5 boundary: wake sampled exactly TMO edges after init
    sendFrame(INIT_P, 4'd8);
    idle(TMO - 1);
    expectWake(cyc + 1, 1'b1, "R5 boundary");
    sendFrame(WAKE_P, 4'd8);
    expectQuiet("R5 boundary");

    // R6: one edge late
    sendFrame(INIT_P, 4'd8);
    idle(TMO);
    sendFrame(WAKE_P, 4'd8);
    expectQuiet("R6");

    // R7: noise between payloads, bad length, corrupted byte
    sendFrame(INIT_P, 4'd8);
    sendFrame(WAKE_P ^ 64'h0000_0000_0010_0000, 4'd8);
    sendFrame(WAKE_P, 4'd7);
    sendFrame(64'h1234_5678_9ABC_DEF0, 4'd8);
    expectQuiet("R7 noise");
    expectWake(cyc + 1, 1'b1, "R7 survives noise");
    sendFrame(WAKE_P, 4'd8);
    expectQuiet("R7 survives noise");

    // R7 / R4: init with wrong length does not start the pair
    sendFrame(INIT_P, 4'd6);
    sendFrame(WAKE_P, 4'd8);
    expectQuiet("R7 short init");

    // R8: direct-from-offline window, at the boundary
    enterListen(1'b1);
    idle(TMO - 1);
    expectWake(cyc + 1, 1'b1, "R8");
    sendFrame(WAKE_P, 4'd8);
    expectQuiet("R8");

    // R9: window expired, wake alone ignored, pair still works
    enterListen(1'b1);
    idle(TMO);
    sendFrame(WAKE_P, 4'd8);
    expectQuiet("R9 expired");
    sendFrame(INIT_P, 4'd8);
    idle(2);
    expectWake(cyc + 1, 1'b1, "R9 pair");
    sendFrame(WAKE_P, 4'd8);
    expectQuiet("R9 pair");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule